// File: doc/BRIEF.md
# Software Pause Frame Generator

This block injects MAC control pause frames into a byte-wide transmit stream on request from software. A host-owned command bit asks the far end of a full-duplex link to stop sending. While the bit is held, the block emits pause frames that carry a programmable 16-bit pause time. It re-sends them often enough that the remote pause never runs out. When the bit is dropped, the block sends one final frame with a zero pause time, which releases the remote transmitter at once. Hardware never raises a pause request of its own.

The generator sits in front of the downstream framing logic, which appends the FCS. It shares one valid/ready byte stream with the normal transmit path and switches between sources only at frame boundaries. A waiting pause or cancel frame goes ahead of the next normal frame. Each generated frame is 60 bytes long:

- the reserved multicast destination 01-80-C2-00-00-01;
- the 48-bit station address from an input port, most significant byte first;
- type 0x8808 and opcode 0x0001;
- the 16-bit pause time, most significant byte first;
- 42 zero bytes.

The refresh interval is measured in pause quanta. An external strobe pulses once per 512 bit times and marks each quantum.

Top module: `pause_gen`

## Requirements
- R1: In full duplex, a 0→1 change of `fc_cmd` causes one pause frame whose timer bytes (offsets 16 and 17, high byte first) equal `pause_time` at the moment the frame starts.
- R2: While `full_duplex` is 0, `fc_cmd` has no effect. No pause or cancel frame is produced, and any request not yet started is discarded. Normal frames still pass.
- R3: Every generated frame is exactly 60 bytes, with `out_last` on the 60th:
  - offsets 0–5 hold 01 80 C2 00 00 01;
  - offsets 6–11 hold `station_addr[47:0]`, high byte first;
  - offsets 12–15 hold 88 08 00 01;
  - offsets 16–17 hold the timer;
  - offsets 18–59 hold zero.
- R4: In full duplex, a 1→0 change of `fc_cmd` causes exactly one frame with timer 0x0000.
- R5: While `fc_cmd` stays 1 in full duplex, a pause frame is requested again on the Nth `quanta_tick` after the previous pause frame's last byte is accepted. N is `pause_time>>1`, or 1 when that is 0.
- R6: A normal frame, once its first byte is accepted, is delivered complete and unbroken. No generated byte appears inside it.
- R7: When a generated frame is waiting and a normal frame is also offered, the generated frame is sent first.
- R8: If `fc_cmd` goes 1→0→1 before the resulting cancel frame has started, the cancel is dropped and a pause frame carrying `pause_time` is sent instead.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_last` hold. `norm_ready` is never 1 while `out_ready` is 0.
- R10: In the cycle after `rst` is sampled high, `out_valid` and `norm_ready` are 0 and no request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| full_duplex | input | 1 | Link is full duplex; pause generation is enabled only here |
| fc_cmd | input | 1 | Software flow-control command bit |
| pause_time | input | 16 | Programmed pause time in quanta |
| station_addr | input | 48 | Source address placed in generated frames |
| quanta_tick | input | 1 | One pulse per 512 bit times |
| norm_valid | input | 1 | Normal path byte valid |
| norm_data | input | 8 | Normal path byte |
| norm_last | input | 1 | Last byte of a normal frame |
| norm_ready | output | 1 | Normal path byte accepted |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Last byte of an output frame |
| out_ready | input | 1 | Downstream accepts the byte |

## Verification
The bench raises the command while a long normal frame is in flight and other normal frames are queued. A design that preempts mid-frame would corrupt the normal frame. A design that lets queued traffic overtake would put the pause after the following frame. A quick 1→0→1 blip during a normal frame checks that the stale cancel is dropped: a design that keeps it would emit a zero-timer frame and release the far end while software still wants it paused. Holding the command with the quantum strobe running measures the refresh distance in ticks, including the case where the interval rounds up to 1. A design that counts off by one, or never refreshes, shows the wrong gap. Half-duplex operation and random backpressure with random frame lengths check that requests are ignored and that bytes hold while stalled.

// File: rtl/pause_gen_pkg.sv
package pause_gen_pkg;

    localparam int FRAME_BYTES = 60;
    localparam int IDX_W       = $clog2(FRAME_BYTES);
    localparam int TIMER_W     = 16;
    localparam int ADDR_W      = 48;
    localparam logic [47:0] CTRL_DEST = 48'h0180C2000001;

    typedef enum logic [1:0] {
        ARB_IDLE  = 2'd0,
        ARB_NORM  = 2'd1,
        ARB_PAUSE = 2'd2
    } arb_state_e;

    typedef struct packed {
        logic       valid;
        logic [7:0] data;
        logic       last;
    } byte_beat_t;

    // byte at position idx of a generated control frame
    function automatic logic [7:0] frame_byte(input logic [IDX_W-1:0] idx,
                                              input logic [ADDR_W-1:0] sa,
                                              input logic [TIMER_W-1:0] tv);
        int i;
        logic [7:0] b;
        i = int'(idx);
        b = 8'h00;
        if (i < 6)
            b = CTRL_DEST[8*(5-i) +: 8];
        else if (i < 12)
            b = sa[8*(11-i) +: 8];
        else begin
            case (i)
                12: b = 8'h88;
                13: b = 8'h08;
                14: b = 8'h00;
                15: b = 8'h01;
                16: b = tv[15:8];
                17: b = tv[7:0];
                default: b = 8'h00;
            endcase
        end
        return b;
    endfunction

    // quanta to wait before refreshing: half the pause time, at least one
    function automatic logic [TIMER_W-1:0] refresh_limit(input logic [TIMER_W-1:0] tv);
        logic [TIMER_W-1:0] h;
        h = tv >> 1;
        return (h == '0) ? TIMER_W'(1) : h;
    endfunction

endpackage

// File: rtl/pause_req_ctrl.sv
module pause_req_ctrl
    import pause_gen_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               full_duplex,
    input  logic               fc_cmd,
    input  logic [TIMER_W-1:0] pause_time,
    input  logic               quanta_tick,
    input  logic               grant,
    input  logic               pause_busy,
    input  logic               pause_done,
    output logic               pend_pause,
    output logic               pend_cancel
);

    logic               cmd_q;
    logic [TIMER_W-1:0] qcnt;
    logic               cmd_rise;
    logic               cmd_fall;
    logic               counting;
    logic               refresh_hit;

    assign cmd_rise    = full_duplex & fc_cmd & ~cmd_q;
    assign cmd_fall    = full_duplex & ~fc_cmd & cmd_q;
    assign counting    = full_duplex & fc_cmd & cmd_q & ~pend_pause & ~pause_busy;
    assign refresh_hit = counting & quanta_tick &
                         (qcnt >= refresh_limit(pause_time) - TIMER_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q       <= 1'b0;
            pend_pause  <= 1'b0;
            pend_cancel <= 1'b0;
            qcnt        <= '0;
        end else begin
            cmd_q <= fc_cmd;
            if (!full_duplex) begin
                pend_pause  <= 1'b0;
                pend_cancel <= 1'b0;
                qcnt        <= '0;
            end else begin
                if (cmd_rise) begin
                    pend_pause  <= 1'b1;
                    pend_cancel <= 1'b0;
                end else if (cmd_fall) begin
                    pend_pause  <= 1'b0;
                    pend_cancel <= 1'b1;
                end else if (grant) begin
                    pend_pause  <= 1'b0;
                    pend_cancel <= 1'b0;
                end else if (refresh_hit) begin
                    pend_pause  <= 1'b1;
                end

                if (pause_done || refresh_hit)
                    qcnt <= '0;
                else if (counting && quanta_tick)
                    qcnt <= qcnt + TIMER_W'(1);
            end
        end
    end

endmodule

// File: rtl/pause_frame_src.sv
module pause_frame_src
    import pause_gen_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [TIMER_W-1:0] load_value,
    input  logic               adv,
    input  logic [ADDR_W-1:0]  station_addr,
    output logic [7:0]         fbyte,
    output logic               flast,
    output logic [IDX_W-1:0]   fidx
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BYTES - 1);

    logic [IDX_W-1:0]   idx;
    logic [TIMER_W-1:0] tv;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
            tv  <= '0;
        end else if (load) begin
            idx <= '0;
            tv  <= load_value;
        end else if (adv && idx != LAST_IDX) begin
            idx <= idx + IDX_W'(1);
        end
    end

    assign fbyte = frame_byte(idx, station_addr, tv);
    assign flast = (idx == LAST_IDX);
    assign fidx  = idx;

endmodule

// File: rtl/pause_tx_arb.sv
module pause_tx_arb
    import pause_gen_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pause_req,
    input  logic [7:0] pause_byte,
    input  logic       pause_last,
    input  logic       norm_valid,
    input  logic [7:0] norm_data,
    input  logic       norm_last,
    output logic       norm_ready,
    input  logic       out_ready,
    output byte_beat_t out_beat,
    output logic       grant,
    output logic       pause_adv,
    output logic       pause_busy,
    output logic       pause_done
);

    arb_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (rst) state <= ARB_IDLE;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx   = state;
        out_beat   = '0;
        norm_ready = 1'b0;
        pause_adv  = 1'b0;
        grant      = 1'b0;
        case (state)
            ARB_IDLE: begin
                if (pause_req) begin
                    grant    = 1'b1;
                    state_nx = ARB_PAUSE;
                end else if (norm_valid) begin
                    state_nx = ARB_NORM;
                end
            end
            ARB_NORM: begin
                out_beat   = '{valid: norm_valid, data: norm_data, last: norm_last};
                norm_ready = out_ready;
                if (norm_valid && out_ready && norm_last)
                    state_nx = ARB_IDLE;
            end
            ARB_PAUSE: begin
                out_beat  = '{valid: 1'b1, data: pause_byte, last: pause_last};
                pause_adv = out_ready;
                if (out_ready && pause_last)
                    state_nx = ARB_IDLE;
            end
            default: state_nx = ARB_IDLE;
        endcase
    end

    assign pause_busy = (state == ARB_PAUSE);
    assign pause_done = pause_busy & out_ready & pause_last;

endmodule

// File: rtl/pause_gen.sv
module pause_gen
    import pause_gen_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        full_duplex,
    input  logic        fc_cmd,
    input  logic [15:0] pause_time,
    input  logic [47:0] station_addr,
    input  logic        quanta_tick,
    input  logic        norm_valid,
    input  logic [7:0]  norm_data,
    input  logic        norm_last,
    output logic        norm_ready,
    output logic        out_valid,
    output logic [7:0]  out_data,
    output logic        out_last,
    input  logic        out_ready
);

    logic               pend_pause;
    logic               pend_cancel;
    logic               grant;
    logic               pause_adv;
    logic               pause_busy;
    logic               pause_done;
    logic [7:0]         pause_byte;
    logic               pause_last;
    logic [IDX_W-1:0]   pause_idx;
    logic [TIMER_W-1:0] load_value;
    byte_beat_t         beat;

    assign load_value = pend_cancel ? '0 : pause_time;

    pause_req_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .full_duplex (full_duplex),
        .fc_cmd      (fc_cmd),
        .pause_time  (pause_time),
        .quanta_tick (quanta_tick),
        .grant       (grant),
        .pause_busy  (pause_busy),
        .pause_done  (pause_done),
        .pend_pause  (pend_pause),
        .pend_cancel (pend_cancel)
    );

    pause_frame_src u_src (
        .clk          (clk),
        .rst          (rst),
        .load         (grant),
        .load_value   (load_value),
        .adv          (pause_adv),
        .station_addr (station_addr),
        .fbyte        (pause_byte),
        .flast        (pause_last),
        .fidx         (pause_idx)
    );

    pause_tx_arb u_arb (
        .clk        (clk),
        .rst        (rst),
        .pause_req  (pend_pause | pend_cancel),
        .pause_byte (pause_byte),
        .pause_last (pause_last),
        .norm_valid (norm_valid),
        .norm_data  (norm_data),
        .norm_last  (norm_last),
        .norm_ready (norm_ready),
        .out_ready  (out_ready),
        .out_beat   (beat),
        .grant      (grant),
        .pause_adv  (pause_adv),
        .pause_busy (pause_busy),
        .pause_done (pause_done)
    );

    assign out_valid = beat.valid;
    assign out_data  = beat.data;
    assign out_last  = beat.last;

endmodule

// File: rtl/pause_gen_chk.sv
module pause_gen_chk
    import pause_gen_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             full_duplex,
    input logic             out_valid,
    input logic [7:0]       out_data,
    input logic             out_last,
    input logic             out_ready,
    input logic             norm_ready,
    input logic             pend_pause,
    input logic             pend_cancel,
    input logic             pause_busy,
    input logic [IDX_W-1:0] pause_idx
);

    // R10
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && !norm_ready && !pend_pause && !pend_cancel));

    // R9
    hold_on_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    // R9
    norm_needs_ready_chk: assert property (@(posedge clk) disable iff (rst)
        norm_ready |-> out_ready);

    // R2
    half_duplex_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !full_duplex |=> (!pend_pause && !pend_cancel));

    // R8
    single_request_chk: assert property (@(posedge clk) disable iff (rst)
        !(pend_pause && pend_cancel));

    // R3
    dest_lead_byte_chk: assert property (@(posedge clk) disable iff (rst)
        (pause_busy && pause_idx == '0) |-> (out_valid && out_data == 8'h01 && !out_last));

    // R6
    no_mixed_source_chk: assert property (@(posedge clk) disable iff (rst)
        !(pause_busy && norm_ready));

endmodule

bind pause_gen pause_gen_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .full_duplex (full_duplex),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .out_last    (out_last),
    .out_ready   (out_ready),
    .norm_ready  (norm_ready),
    .pend_pause  (pend_pause),
    .pend_cancel (pend_cancel),
    .pause_busy  (pause_busy),
    .pause_idx   (pause_idx)
);

// File: tb/pause_gen_test.sv
module pause_gen_test;

    localparam int CLK_PERIOD = 10;
    localparam logic [47:0] SA = 48'h0A1B2C3D4E5F;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        full_duplex = 1'b0;
    logic        fc_cmd = 1'b0;
    logic [15:0] pause_time = 16'h0000;
    logic        quanta_tick = 1'b0;
    logic        norm_valid = 1'b0;
    logic [7:0]  norm_data = 8'h00;
    logic        norm_last = 1'b0;
    logic        norm_ready;
    logic        out_valid;
    logic [7:0]  out_data;
    logic        out_last;
    logic        out_ready = 1'b1;

    pause_gen uut (
        .clk          (clk),
        .rst          (rst),
        .full_duplex  (full_duplex),
        .fc_cmd       (fc_cmd),
        .pause_time   (pause_time),
        .station_addr (SA),
        .quanta_tick  (quanta_tick),
        .norm_valid   (norm_valid),
        .norm_data    (norm_data),
        .norm_last    (norm_last),
        .norm_ready   (norm_ready),
        .out_valid    (out_valid),
        .out_data     (out_data),
        .out_last     (out_last),
        .out_ready    (out_ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // normal traffic model
    int nlen [0:255];
    int norm_limit = 0;
    int nf_drv = 0;
    int nb_drv = 0;
    bit norm_hs = 0;
    bit rnd_ready = 0;
    bit tick_en = 0;
    int cyc = 0;

    function automatic logic [7:0] nbyte(input int f, input int i);
        if (i == 0) return 8'h02;
        return 8'((f * 29 + i * 7 + 3) & 255);
    endfunction

    function automatic logic [7:0] exp_ctrl_byte(input int i, input logic [15:0] v);
        logic [47:0] d;
        d = 48'h0180C2000001;
        if (i < 6)  return d[8*(5-i) +: 8];
        if (i < 12) return SA[8*(11-i) +: 8];
        case (i)
            12: return 8'h88;
            13: return 8'h08;
            14: return 8'h00;
            15: return 8'h01;
            16: return v[15:8];
            17: return v[7:0];
            default: return 8'h00;
        endcase
    endfunction

    task automatic add_norm(input int len);
        nlen[norm_limit] = len;
        norm_limit++;
    endtask

    // driver: inputs change one time unit after the rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (norm_hs) begin
                if (nb_drv == nlen[nf_drv] - 1) begin
                    nf_drv++;
                    nb_drv = 0;
                end else begin
                    nb_drv++;
                end
            end
            norm_valid = (nf_drv < norm_limit);
            norm_data  = nbyte(nf_drv, nb_drv);
            norm_last  = (nb_drv == nlen[nf_drv] - 1);
            out_ready  = rnd_ready ? (($urandom % 4) != 0) : 1'b1;
            cyc++;
            quanta_tick = tick_en && (cyc % 4 == 0);
        end
    end

    // monitor at the falling edge
    logic [7:0] fbuf [0:63];
    int  fb = 0;
    int  nframes = 0;
    bit  kinds [0:1023];
    logic [15:0] pvals [0:1023];
    int  n_pause = 0;
    int  n_zero = 0;
    int  n_nz = 0;
    int  mon_nf = 0;
    int  tick_ctr = 0;
    int  gaps [0:255];
    int  gcount = 0;
    bit  hold_pend = 0;
    logic [7:0] hold_data;
    bit  hold_last;

    task automatic close_frame();
        int len;
        bit ok;
        logic [15:0] v;
        len = fb;
        if (len == 60 && fbuf[0] == 8'h01) begin
            v = {fbuf[16], fbuf[17]};
            ok = 1;
            for (int i = 0; i < 60; i++)
                if (fbuf[i] !== exp_ctrl_byte(i, v)) ok = 0;
            chk(ok, "R3 control frame layout", longint'(v), longint'(v));
            kinds[nframes] = 1;
            pvals[nframes] = v;
            n_pause++;
            if (v == 16'h0) n_zero++; else n_nz++;
        end else begin
            ok = (len == nlen[mon_nf]);
            for (int i = 0; i < len && i < 64; i++)
                if (fbuf[i] !== nbyte(mon_nf, i)) ok = 0;
            chk(ok, "R6 normal frame intact", longint'(len), longint'(nlen[mon_nf]));
            kinds[nframes] = 0;
            pvals[nframes] = 16'h0;
            mon_nf++;
        end
        nframes++;
    endtask

    initial begin
        forever begin
            @(negedge clk);
            norm_hs = norm_valid && norm_ready;
            if (!rst) begin
                if (hold_pend)
                    chk(out_valid && out_data == hold_data && out_last == hold_last,
                        "R9 hold while stalled", longint'(out_data), longint'(hold_data));
                hold_pend = out_valid && !out_ready;
                hold_data = out_data;
                hold_last = out_last;
                if (out_valid && out_ready) begin
                    if (fb == 0 && out_data == 8'h01) begin
                        gaps[gcount] = tick_ctr;
                        gcount++;
                    end
                    if (fb < 64) fbuf[fb] = out_data;
                    fb++;
                    if (out_last) begin
                        close_frame();
                        fb = 0;
                        if (kinds[nframes-1]) tick_ctr = 0;
                        else if (quanta_tick) tick_ctr++;
                    end else if (quanta_tick) tick_ctr++;
                end else if (quanta_tick) tick_ctr++;
            end
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_frames(input int target, input int maxc);
        int c = 0;
        while (nframes < target && c < maxc) begin
            @(negedge clk);
            c++;
        end
    endtask

    task automatic wait_pauses(input int target, input int maxc);
        int c = 0;
        while (n_pause < target && c < maxc) begin
            @(negedge clk);
            c++;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int base;
        int pb;
        int g0;
        int rises;
        int falls;
        logic [15:0] v;
        void'($urandom(32'd20240611));

        // R10 reset state
        wait_cyc(4);
        chk(!out_valid && !norm_ready, "R10 idle after reset",
            longint'({out_valid, norm_ready}), 0);
        rst = 1'b0;
        wait_cyc(3);
        chk(!out_valid, "R10 no output without traffic", longint'(out_valid), 0);

        // R2 half duplex: command ignored, normal traffic passes
        full_duplex = 1'b0;
        pause_time = 16'h1234;
        fc_cmd = 1'b1;
        add_norm(12);
        add_norm(5);
        wait_cyc(200);
        fc_cmd = 1'b0;
        wait_cyc(200);
        chk(n_pause == 0, "R2 no control frame in half duplex", longint'(n_pause), 0);
        chk(mon_nf == 2, "R2 normal frames pass in half duplex", longint'(mon_nf), 2);

        // R1 / R4: pause then cancel
        full_duplex = 1'b1;
        wait_cyc(5);
        base = nframes;
        pause_time = 16'hA5C3;
        fc_cmd = 1'b1;
        wait_frames(base + 1, 500);
        chk(nframes == base + 1 && kinds[base] && pvals[base] == 16'hA5C3,
            "R1 pause frame carries pause_time", longint'(pvals[base]), 64'hA5C3);
        wait_cyc(300);
        chk(nframes == base + 1, "R1 single pause without ticks", longint'(nframes), longint'(base + 1));
        fc_cmd = 1'b0;
        wait_cyc(400);
        chk(nframes == base + 2, "R4 exactly one cancel frame", longint'(nframes), longint'(base + 2));
        chk(kinds[base + 1] && pvals[base + 1] == 16'h0, "R4 cancel timer zero",
            longint'(pvals[base + 1]), 0);

        // R7 / R6: request raised during a normal frame with more queued
        base = nframes;
        pb = mon_nf;
        pause_time = 16'h0777;
        add_norm(30);
        add_norm(30);
        add_norm(30);
        wait_cyc(8);
        fc_cmd = 1'b1;
        wait_frames(base + 4, 1000);
        chk(!kinds[base] && kinds[base + 1] && !kinds[base + 2] && !kinds[base + 3],
            "R7 pause goes ahead of next normal frame",
            longint'({kinds[base], kinds[base+1], kinds[base+2], kinds[base+3]}), 64'h4);
        chk(mon_nf == pb + 3, "R6 all normal frames delivered", longint'(mon_nf), longint'(pb + 3));

        // R8: 1->0->1 blip while a normal frame is in flight
        wait_cyc(50);
        base = nframes;
        pause_time = 16'h3C3C;
        add_norm(40);
        wait_cyc(6);
        fc_cmd = 1'b0;
        wait_cyc(3);
        fc_cmd = 1'b1;
        wait_cyc(400);
        chk(nframes == base + 2, "R8 cancel dropped", longint'(nframes), longint'(base + 2));
        chk(!kinds[base] && kinds[base + 1] && pvals[base + 1] == 16'h3C3C,
            "R8 fresh pause frame sent", longint'(pvals[base + 1]), 64'h3C3C);
        fc_cmd = 1'b0;
        wait_cyc(300);
        chk(nframes == base + 3 && pvals[base + 2] == 16'h0, "R4 cancel after blip test",
            longint'(nframes), longint'(base + 3));

        // R5 refresh with interval 4 quanta
        pause_time = 16'd8;
        tick_en = 1;
        g0 = gcount;
        pb = n_pause;
        fc_cmd = 1'b1;
        wait_pauses(pb + 4, 2000);
        fc_cmd = 1'b0;
        tick_en = 0;
        wait_cyc(300);
        chk(gcount >= g0 + 3 && gaps[g0 + 1] == 4, "R5 refresh gap (time 8)",
            longint'(gaps[g0 + 1]), 4);
        chk(gcount >= g0 + 3 && gaps[g0 + 2] == 4, "R5 second refresh gap (time 8)",
            longint'(gaps[g0 + 2]), 4);

        // R5 refresh with interval rounded up to 1
        pause_time = 16'd1;
        tick_en = 1;
        g0 = gcount;
        pb = n_pause;
        fc_cmd = 1'b1;
        wait_pauses(pb + 3, 2000);
        fc_cmd = 1'b0;
        tick_en = 0;
        wait_cyc(300);
        chk(gcount >= g0 + 2 && gaps[g0 + 1] == 1, "R5 refresh gap (minimum one)",
            longint'(gaps[g0 + 1]), 1);

        // random phase: backpressure, random frames, spaced toggles
        rnd_ready = 1;
        pb = mon_nf + 30;
        for (int k = 0; k < 30; k++) add_norm(1 + int'($urandom % 24));
        base = n_nz;
        g0 = n_zero;
        rises = 0;
        falls = 0;
        for (int k = 0; k < 8; k++) begin
            v = 16'($urandom) | 16'h0001;
            pause_time = v;
            fc_cmd = ~fc_cmd;
            if (fc_cmd) rises++; else falls++;
            wait_cyc(300);
        end
        wait_cyc(400);
        rnd_ready = 0;
        wait_cyc(100);
        chk(n_nz - base == rises, "R1 one pause per rise (random)",
            longint'(n_nz - base), longint'(rises));
        chk(n_zero - g0 == falls, "R4 one cancel per fall (random)",
            longint'(n_zero - g0), longint'(falls));
        chk(mon_nf == pb, "R6 normal frames intact under backpressure",
            longint'(mon_nf), longint'(pb));

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule